// File: doc/BRIEF.md
# Oversampled Serial Receiver with Sticky Error Status

The block turns an asynchronous serial line into bytes that software collects through a small register port. It uses a 16x oversampling clock to find the start bit, confirms it at mid-bit, and samples each data bit at its centre, least significant bit first. An optional parity bit and one stop bit follow. Each finished frame goes into a data register and raises a data-full flag. A parity mismatch, a low stop bit, or a frame that finishes while the previous byte is still unread raises an error flag.

Error flags are sticky. While any of them is set, the receiver accepts no new frame until software has cleared all three. Reading the data register clears the data-full flag as a side effect. The status register also shows the current level of the line, so after a framing error software can tell a held-low break from a corrupted frame.

Top module: `srx_top`

## Requirements
- R1: After reset the control register (address 0) reads 0, the data register (address 2) reads 0, and the status register (address 1) has bits 3..0 at 0 and bit 4 equal to the line level.
- R2: With control bit 0 (enable) set, a frame of one low start bit, 8 data bits sent LSB first and one high stop bit is captured into the data register, and status bit 0 (data full) becomes 1.
- R3: A low pulse on the line shorter than half a bit time is rejected as a false start, and no frame is captured.
- R4: With control bit 1 (parity on) set, a parity bit follows the data. Control bit 2 selects odd parity when 1 and even parity when 0. On a mismatch, status bit 2 (parity error) is set, and the byte is still loaded.
- R5: A stop bit sampled as 0 sets status bit 3 (framing error), and the byte is still loaded. Status bit 4 shows the live line level, so a break reads as 0 there.
- R6: A read of the data register returns the byte and clears the data-full flag on the next clock.
- R7: If a frame completes while data full is 1, status bit 1 (overrun) is set, the data register keeps its old byte, and the new byte is dropped.
- R8: While any of status bits 1..3 is set, no new frame is received. Reception resumes once all three are 0.
- R9: Writing the status register clears each of bits 1..3 that is written as 0. Writing 1 to these bits has no effect, and data full cannot be written.
- R10: With the enable bit at 0, the receiver stays idle and frames on the line are not captured.
- R11: When a read of the data register falls in the same clock as a frame completion, the read takes effect first. No overrun is flagged, the new byte is loaded, and data full stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Serial receive line, idle high |
| addr_i | input | 2 | Register address: 0 control, 1 status, 2 data |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe; triggers side effects on the data register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the addressed register, combinational |

## Verification
A software read of the data register and the completion of the next frame can fall in the same clock. If both happen there, the result decides whether an overrun is reported. The bench leaves one byte unread, then starts a second frame. In parallel it counts clocks from the second frame's start edge to the exact cycle in which the completed frame reaches the registers, and holds the data read strobe in that cycle alone. It passes the case only if the read returned the first byte, the status afterwards shows data full without overrun, and the data register holds the second byte.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int DATA_W = 8;
  localparam int REG_W  = 8;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  localparam int CTRL_EN  = 0;
  localparam int CTRL_PEN = 1;
  localparam int CTRL_ODD = 2;

  localparam int STAT_FULL = 0;
  localparam int STAT_OVR  = 1;
  localparam int STAT_PERR = 2;
  localparam int STAT_FERR = 3;
  localparam int STAT_LINE = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              par_err;
    logic              frm_err;
  } rx_result_t;
endpackage

// File: rtl/srx_tick_gen.sv
module srx_tick_gen #(
  parameter int DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] TOP = CW'(DIV - 1);

  logic [CW-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       div_q <= '0;
    else if (restart_i || div_q == TOP) div_q <= '0;
    else                               div_q <= div_q + 1'b1;
  end

  assign tick_o = (div_q == TOP);
endmodule

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;  // line idles high
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/srx_deser.sv
module srx_deser
  import srx_pkg::*;
#(
  parameter int OVS = 16  // power of two: tick counter wraps naturally
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rxd_i,
  input  logic       enable_i,
  input  logic       hold_i,
  input  logic       par_en_i,
  input  logic       par_odd_i,
  output logic       restart_o,
  output logic       done_o,
  output logic       idle_o,
  output rx_result_t result_o
);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(DATA_W);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam logic [BW-1:0] BLAST = BW'(DATA_W - 1);

  rx_state_e         state_q;
  logic [CW-1:0]     cnt_q;
  logic [BW-1:0]     bit_q;
  logic [DATA_W-1:0] shreg_q;
  logic              par_q;
  logic              done_q;
  rx_result_t        res_q;
  logic              samp;

  // done_q guard keeps a low stop bit from retriggering before flags land
  assign restart_o = (state_q == ST_IDLE) && enable_i && !hold_i && !done_q && !rxd_i;
  assign samp      = tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      shreg_q <= '0;
      par_q   <= 1'b0;
      done_q  <= 1'b0;
      res_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!enable_i) begin
        state_q <= ST_IDLE;
      end else begin
        case (state_q)
          ST_IDLE: begin
            if (restart_o) begin
              state_q <= ST_START;
              cnt_q   <= '0;
            end
          end
          ST_START: begin
            if (tick_i) begin
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == MID) begin
                cnt_q   <= '0;
                bit_q   <= '0;
                state_q <= rxd_i ? ST_IDLE : ST_DATA;
              end
            end
          end
          ST_DATA: begin
            if (tick_i) cnt_q <= cnt_q + 1'b1;
            if (samp) begin
              shreg_q <= {rxd_i, shreg_q[DATA_W-1:1]};
              if (bit_q == BLAST) state_q <= par_en_i ? ST_PAR : ST_STOP;
              else                bit_q   <= bit_q + 1'b1;
            end
          end
          ST_PAR: begin
            if (tick_i) cnt_q <= cnt_q + 1'b1;
            if (samp) begin
              par_q   <= rxd_i;
              state_q <= ST_STOP;
            end
          end
          ST_STOP: begin
            if (tick_i) cnt_q <= cnt_q + 1'b1;
            if (samp) begin
              done_q        <= 1'b1;
              res_q.data    <= shreg_q;
              res_q.frm_err <= ~rxd_i;
              res_q.par_err <= par_en_i & ((^shreg_q ^ par_q) != par_odd_i);
              state_q       <= ST_IDLE;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign done_o   = done_q;
  assign idle_o   = (state_q == ST_IDLE);
  assign result_o = res_q;
endmodule

// File: rtl/srx_regs.sv
module srx_regs
  import srx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              done_i,
  input  rx_result_t        result_i,
  input  logic              line_i,
  output logic              rx_en_o,
  output logic              par_en_o,
  output logic              par_odd_o,
  output logic              err_any_o,
  output logic              full_o,
  output logic              ovr_o,
  output logic [DATA_W-1:0] rdr_o
);
  logic              rx_en_q, par_en_q, par_odd_q;
  logic              full_q, ovr_q, perr_q, ferr_q;
  logic [DATA_W-1:0] rdr_q;
  logic              wr_ctrl, wr_stat, rd_data;

  assign wr_ctrl = wr_en_i && (addr_i == ADDR_CTRL);
  assign wr_stat = wr_en_i && (addr_i == ADDR_STAT);
  assign rd_data = rd_en_i && (addr_i == ADDR_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_en_q   <= 1'b0;
      par_en_q  <= 1'b0;
      par_odd_q <= 1'b0;
      full_q    <= 1'b0;
      ovr_q     <= 1'b0;
      perr_q    <= 1'b0;
      ferr_q    <= 1'b0;
      rdr_q     <= '0;
    end else begin
      if (wr_ctrl) begin
        rx_en_q   <= wdata_i[CTRL_EN];
        par_en_q  <= wdata_i[CTRL_PEN];
        par_odd_q <= wdata_i[CTRL_ODD];
      end
      // software clears by writing 0; hardware set below wins
      if (wr_stat) begin
        if (!wdata_i[STAT_OVR])  ovr_q  <= 1'b0;
        if (!wdata_i[STAT_PERR]) perr_q <= 1'b0;
        if (!wdata_i[STAT_FERR]) ferr_q <= 1'b0;
      end
      if (done_i) begin
        // a same-cycle data read counts as having emptied the register
        if (full_q && !rd_data) begin
          ovr_q <= 1'b1;
        end else begin
          rdr_q  <= result_i.data;
          full_q <= 1'b1;
          if (result_i.par_err) perr_q <= 1'b1;
          if (result_i.frm_err) ferr_q <= 1'b1;
        end
      end else if (rd_data) begin
        full_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_CTRL: begin
        rdata_o[CTRL_EN]  = rx_en_q;
        rdata_o[CTRL_PEN] = par_en_q;
        rdata_o[CTRL_ODD] = par_odd_q;
      end
      ADDR_STAT: begin
        rdata_o[STAT_FULL] = full_q;
        rdata_o[STAT_OVR]  = ovr_q;
        rdata_o[STAT_PERR] = perr_q;
        rdata_o[STAT_FERR] = ferr_q;
        rdata_o[STAT_LINE] = line_i;
      end
      ADDR_DATA: rdata_o = rdr_q;
      default:   rdata_o = '0;
    endcase
  end

  assign rx_en_o   = rx_en_q;
  assign par_en_o  = par_en_q;
  assign par_odd_o = par_odd_q;
  assign err_any_o = ovr_q | perr_q | ferr_q;
  assign full_o    = full_q;
  assign ovr_o     = ovr_q;
  assign rdr_o     = rdr_q;
endmodule

// File: rtl/srx_top.sv
module srx_top
  import srx_pkg::*;
#(
  parameter int CLK_PER_TICK = 8,
  parameter int OVS          = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rxd_i,
  input  logic [1:0]       addr_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o
);
  logic              rxd_s;
  logic              tick, restart;
  logic              rx_done, rx_idle;
  rx_result_t        rx_res;
  logic              rx_en, par_en, par_odd, err_any;
  logic              full, ovr;
  logic [DATA_W-1:0] rdr;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (rxd_s)
  );

  srx_tick_gen #(.DIV(CLK_PER_TICK)) u_tick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart),
    .tick_o   (tick)
  );

  srx_deser #(.OVS(OVS)) u_deser (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .rxd_i    (rxd_s),
    .enable_i (rx_en),
    .hold_i   (err_any),
    .par_en_i (par_en),
    .par_odd_i(par_odd),
    .restart_o(restart),
    .done_o   (rx_done),
    .idle_o   (rx_idle),
    .result_o (rx_res)
  );

  srx_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .done_i   (rx_done),
    .result_i (rx_res),
    .line_i   (rxd_s),
    .rx_en_o  (rx_en),
    .par_en_o (par_en),
    .par_odd_o(par_odd),
    .err_any_o(err_any),
    .full_o   (full),
    .ovr_o    (ovr),
    .rdr_o    (rdr)
  );
endmodule

// File: rtl/srx_chk.sv
module srx_chk
  import srx_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        addr_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic              done,
  input logic              idle,
  input logic              err_any,
  input logic              rx_en,
  input logic              full,
  input logic              ovr,
  input logic [DATA_W-1:0] rdr
);
  logic rd_data, wr_stat;
  assign rd_data = rd_en_i && (addr_i == ADDR_DATA);
  assign wr_stat = wr_en_i && (addr_i == ADDR_STAT);

  // R6
  rd_clears_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data && !done) |=> !full);

  // R7
  ovr_keeps_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && full && !rd_data) |=> (ovr && rdr == $past(rdr)));

  // R8
  frozen_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_any && idle) |=> idle);

  // R9
  w1_no_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && !ovr && !done) |=> !ovr);

  // R10
  disabled_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en |=> idle);

  // R11
  read_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && rd_data && !ovr) |=> (full && !ovr));
endmodule

bind srx_top srx_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_i (addr_i),
  .wr_en_i(wr_en_i),
  .rd_en_i(rd_en_i),
  .done   (rx_done),
  .idle   (rx_idle),
  .err_any(err_any),
  .rx_en  (rx_en),
  .full   (full),
  .ovr    (ovr),
  .rdr    (rdr)
);

// File: tb/sim_srx_top.sv
`timescale 1ns/1ps
module sim_srx_top;
  localparam int K = 4;
  localparam int BIT = 16 * K;
  localparam int STOP_TICK = 8 + 16 * 9;  // stop sample tick, no parity

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] addr = 2'd0;
  logic       wr = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  srx_top #(.CLK_PER_TICK(K)) u0 (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .rxd_i  (rxd),
    .addr_i (addr),
    .wr_en_i(wr),
    .rd_en_i(rd),
    .wdata_i(wdata),
    .rdata_o(rdata)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic expect_reg(input string req, input logic [1:0] a, input logic [7:0] exp);
    logic [7:0] v;
    reg_rd(a, v);
    chk(req, v, exp);
  endtask

  // call just after a falling clock edge
  task automatic send_frame(input logic [7:0] d, input bit use_par, input bit par_bit,
                            input bit stop_bit, input bit hold_low);
    rxd = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (BIT) @(negedge clk);
    end
    if (use_par) begin
      rxd = par_bit;
      repeat (BIT) @(negedge clk);
    end
    rxd = stop_bit;
    repeat (BIT) @(negedge clk);
    if (!hold_low) rxd = 1'b1;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic tx(input logic [7:0] d);
    @(negedge clk);
    send_frame(d, 1'b0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_reset;
    expect_reg("R1 ctrl", 2'd0, 8'h00);
    expect_reg("R1 stat", 2'd1, 8'h10);
    expect_reg("R1 data", 2'd2, 8'h00);
  endtask

  task automatic t_basic;
    reg_wr(2'd0, 8'h01);
    tx(8'hA5);
    expect_reg("R2 stat full", 2'd1, 8'h11);
    expect_reg("R2 data A5", 2'd2, 8'hA5);
    expect_reg("R6 full cleared", 2'd1, 8'h10);
    tx(8'h01);
    expect_reg("R2 data 01", 2'd2, 8'h01);
    tx(8'h80);
    expect_reg("R2 data 80", 2'd2, 8'h80);
    expect_reg("R6 stat after read", 2'd1, 8'h10);
  endtask

  task automatic t_glitch;
    @(negedge clk);
    rxd = 1'b0;
    repeat (4 * K) @(negedge clk);
    rxd = 1'b1;
    repeat (12 * BIT) @(negedge clk);
    expect_reg("R3 glitch rejected", 2'd1, 8'h10);
  endtask

  task automatic t_parity;
    reg_wr(2'd0, 8'h03);  // even parity
    @(negedge clk); send_frame(8'h5B, 1'b1, ^8'h5B, 1'b1, 1'b0);
    expect_reg("R4 even ok stat", 2'd1, 8'h11);
    expect_reg("R4 even ok data", 2'd2, 8'h5B);
    @(negedge clk); send_frame(8'h6E, 1'b1, ~(^8'h6E), 1'b1, 1'b0);
    expect_reg("R4 even bad stat", 2'd1, 8'h15);
    expect_reg("R4 bad data loaded", 2'd2, 8'h6E);
    reg_wr(2'd1, 8'h00);
    reg_wr(2'd0, 8'h07);  // odd parity
    @(negedge clk); send_frame(8'h6E, 1'b1, ~(^8'h6E), 1'b1, 1'b0);
    expect_reg("R4 odd ok stat", 2'd1, 8'h11);
    expect_reg("R4 odd ok data", 2'd2, 8'h6E);
  endtask

  task automatic t_freeze;
    reg_wr(2'd0, 8'h03);
    @(negedge clk); send_frame(8'h11, 1'b1, 1'b1, 1'b1, 1'b0);  // wrong even parity
    expect_reg("R8 perr data", 2'd2, 8'h11);
    reg_wr(2'd1, 8'hFF);
    expect_reg("R9 write ones keeps perr", 2'd1, 8'h14);
    @(negedge clk); send_frame(8'h22, 1'b1, ^8'h22, 1'b1, 1'b0);
    expect_reg("R8 frozen stat", 2'd1, 8'h14);
    expect_reg("R8 frozen data", 2'd2, 8'h11);
    reg_wr(2'd1, 8'h00);
    expect_reg("R9 write zero clears", 2'd1, 8'h10);
    reg_wr(2'd1, 8'h0E);
    expect_reg("R9 write ones no set", 2'd1, 8'h10);
    @(negedge clk); send_frame(8'h33, 1'b1, ^8'h33, 1'b1, 1'b0);
    expect_reg("R8 resumed data", 2'd2, 8'h33);
  endtask

  task automatic t_overrun;
    reg_wr(2'd0, 8'h01);
    tx(8'h44);
    tx(8'h55);
    expect_reg("R7 overrun stat", 2'd1, 8'h13);
    expect_reg("R7 old data kept", 2'd2, 8'h44);
    reg_wr(2'd1, 8'h01);
    expect_reg("R9 full not writable", 2'd1, 8'h10);
  endtask

  task automatic t_break;
    reg_wr(2'd0, 8'h01);
    @(negedge clk); send_frame(8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
    expect_reg("R5 break stat", 2'd1, 8'h09);
    expect_reg("R5 break data", 2'd2, 8'h00);
    @(negedge clk); rxd = 1'b1;
    repeat (8) @(negedge clk);
    expect_reg("R5 line high again", 2'd1, 8'h18);
    reg_wr(2'd1, 8'h00);
    expect_reg("R5 cleared", 2'd1, 8'h10);
  endtask

  task automatic t_disable;
    reg_wr(2'd0, 8'h00);
    tx(8'h77);
    expect_reg("R10 disabled stat", 2'd1, 8'h10);
    expect_reg("R10 disabled data", 2'd2, 8'h00);
  endtask

  task automatic t_coincide;
    logic [7:0] got;
    reg_wr(2'd0, 8'h01);
    tx(8'h12);
    @(negedge clk);
    fork
      send_frame(8'h34, 1'b0, 1'b0, 1'b1, 1'b0);
      begin
        // frame result reaches the registers on posedge STOP_TICK*K+4
        repeat (STOP_TICK * K + 3) @(posedge clk);
        @(negedge clk); addr = 2'd2; rd = 1'b1;
        #1 got = rdata;
        @(negedge clk); rd = 1'b0;
      end
    join
    chk("R11 read returns old byte", got, 8'h12);
    expect_reg("R11 no overrun, full", 2'd1, 8'h11);
    expect_reg("R11 new byte loaded", 2'd2, 8'h34);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_glitch();
    t_parity();
    t_freeze();
    t_overrun();
    t_break();
    t_disable();
    t_coincide();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule